// File: doc/BRIEF.md
# Balanced Ternary Adder Tree

This block adds N single-trit operands, each holding -1, 0 or +1, and returns their total as a multi-trit balanced-ternary word. Operands enter side by side as a packed vector of 2-bit codes, one code per trit. The block pairs the operands and reduces them level by level. Each pairwise adder is a ripple of ternary cells whose signed carry is -1, 0 or +1. The lowest position of each pairwise adder uses a half-adder cell, since no carry enters there. Every other position uses a full-adder cell.

The number of levels is log2(N). At level k the word width is the smallest trit count that covers ±2^k. A carry that leaves that width can be shown to be zero, so it is dropped. With N = 16 the four levels produce words of 2, 2, 3 and 4 trits.

A parameter selects one of two builds. The combinational build gives its result in the same cycle. The pipelined build places a register after every level, and a valid flag travels alongside the data.

Top module: `tern_adder_tree`

## Requirements
- R1: Each trit uses a 2-bit code: 2'b01 means +1, 2'b00 means 0 and 2'b11 means -1. Operand i sits in bits [2i+1:2i] of `in_trits`. The code 2'b10 is read as 0.
- R2: Trit j of `out_sum` sits in bits [2j+1:2j] and has weight 3^j. The value of `out_sum` equals the integer sum of the N operands.
- R3: No trit of `out_sum` ever carries the code 2'b10.
- R4: `out_sum` is ceil(log3(2N+1)) trits wide, which is 4 trits for N = 16. When all 16 operands are +1 the word is 8'b01_11_11_01 (+16). When all are -1 the word is 8'b11_01_01_11 (-16). The value never leaves the range -N to +N.
- R5: In the pipelined build, `out_valid` and the matching `out_sum` appear exactly log2(N) clock edges after `in_valid` and its operands are captured.
- R6: In the combinational build, `out_valid` equals `in_valid` and `out_sum` reflects the present operands with no clock edge in between.
- R7: In the pipelined build, a low `rst_n` clears `out_valid` and `out_sum` at once. Both stay cleared for as long as reset is held, whatever the inputs do.
- R8: The pipelined build accepts a new operand vector on every clock edge. Back-to-back vectors come out in order, each one carrying its own sum.
- R9: Patterns with heavy cancellation give exact results. Alternating +1/-1 gives 0. Alternating +1/0 gives +N/2. Alternating -1/0 gives -N/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; used only by the pipelined build |
| rst_n | input | 1 | Asynchronous active-low reset of the level registers |
| in_valid | input | 1 | Marks the operand vector as meaningful |
| in_trits | input | 2*N | N operand trit codes, operand 0 in the low bits |
| out_valid | output | 1 | Marks `out_sum` as the result of a valid vector |
| out_sum | output | 2*WOUT | Balanced-ternary total, least significant trit in the low bits |

## Verification
The bench targets the extremes: all +1, all -1 and the alternating patterns. These are the cases that drive every level's carry chain to its limit. A design that trimmed one trit too many, or mishandled a negative carry, would show a wrong top trit or a sign error exactly there. Vectors full of the unused code 2'b10 check that this code counts as zero and not as -2. Streams with no gaps, and streams with random gaps in valid, check that each result lines up with its own valid flag. A pipeline that was one level short or one level long would pair sums with the wrong flags. The bench also asserts reset in the middle of a stream to confirm that the output clears at once and not on the next edge.

// File: rtl/tern_pkg.sv
package tern_pkg;

   typedef logic [1:0] trit_t;

   localparam trit_t T_POS  = 2'b01;
   localparam trit_t T_ZERO = 2'b00;
   localparam trit_t T_NEG  = 2'b11;

   // signed value of a trit code; the unused code 2'b10 reads as zero
   function automatic logic signed [2:0] t2i(trit_t t);
      case (t)
         T_POS:   return 3'sd1;
         T_NEG:   return -3'sd1;
         default: return 3'sd0;
      endcase
   endfunction

   function automatic trit_t i2t(logic signed [2:0] v);
      if (v > 3'sd0)      return T_POS;
      else if (v < 3'sd0) return T_NEG;
      else                return T_ZERO;
   endfunction

   // smallest number of trits able to hold every value in -mag..+mag
   function automatic int trits_for(int mag);
      int w;
      int span;
      w    = 1;
      span = 3;
      while (span < 2 * mag + 1) begin
         span = span * 3;
         w    = w + 1;
      end
      return w;
   endfunction

endpackage

// File: rtl/tern_cell.sv
module tern_cell import tern_pkg::*; #(
   parameter bit HALF = 1'b0
) (
   input  trit_t a,
   input  trit_t b,
   input  trit_t ci,
   output trit_t s,
   output trit_t co
);

   logic signed [2:0] vc;
   logic signed [2:0] tot;
   logic signed [2:0] sv;

   generate
      if (HALF) begin : g_half
         logic unused_ci;
         assign unused_ci = ^ci;
         assign vc = 3'sd0;
      end else begin : g_full
         assign vc = t2i(ci);
      end
   endgenerate

   always_comb begin
      tot = t2i(a) + t2i(b) + vc;
      if (tot > 3'sd1) begin
         co = T_POS;
         sv = tot - 3'sd3;
      end else if (tot < -3'sd1) begin
         co = T_NEG;
         sv = tot + 3'sd3;
      end else begin
         co = T_ZERO;
         sv = tot;
      end
      s = i2t(sv);
   end

endmodule

// File: rtl/tern_pair_add.sv
module tern_pair_add import tern_pkg::*; #(
   parameter int W_IN  = 1,
   parameter int W_OUT = 2
) (
   input  logic [2*W_IN-1:0]  a,
   input  logic [2*W_IN-1:0]  b,
   output logic [2*W_OUT-1:0] s
);

   trit_t cy [0:W_OUT];

   if (W_OUT < W_IN) begin : g_bad_width
      $error("tern_pair_add: output narrower than input");
   end
   if (W_OUT > W_IN + 1) begin : g_bad_growth
      $error("tern_pair_add: width may grow by one trit at most");
   end

   assign cy[0] = T_ZERO;

   generate
      for (genvar i = 0; i < W_OUT; i++) begin : g_pos
         if (i < W_IN) begin : g_add
            tern_cell #(.HALF(i == 0)) u_cell (
               .a  (a[2*i +: 2]),
               .b  (b[2*i +: 2]),
               .ci (cy[i]),
               .s  (s[2*i +: 2]),
               .co (cy[i+1])
            );
         end else begin : g_carry
            assign s[2*i +: 2] = cy[i];
            assign cy[i+1]     = T_ZERO;
         end
      end
   endgenerate

   // cy[W_OUT] is the trimmed carry; the width rule keeps it at zero
   logic unused_top_carry;
   assign unused_top_carry = ^cy[W_OUT];

endmodule

// File: rtl/tern_stage.sv
module tern_stage import tern_pkg::*; #(
   parameter int BUS   = 32,
   parameter int PAIRS = 8,
   parameter int W_IN  = 1,
   parameter int W_OUT = 2,
   parameter bit REG   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           v_i,
   input  logic [BUS-1:0] d_i,
   output logic           v_o,
   output logic [BUS-1:0] d_o
);

   localparam int USED_I = 2 * W_IN * 2 * PAIRS;
   localparam int USED_O = 2 * W_OUT * PAIRS;

   logic [USED_O-1:0] sums;

   if (USED_I > BUS || USED_O > BUS) begin : g_bad_bus
      $error("tern_stage: level does not fit the bus");
   end

   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         tern_pair_add #(.W_IN(W_IN), .W_OUT(W_OUT)) u_pair (
            .a (d_i[(2*p)   * 2*W_IN +: 2*W_IN]),
            .b (d_i[(2*p+1) * 2*W_IN +: 2*W_IN]),
            .s (sums[p * 2*W_OUT +: 2*W_OUT])
         );
      end

      if (USED_I < BUS) begin : g_in_pad
         logic unused_hi;
         assign unused_hi = ^d_i[BUS-1:USED_I];
      end

      logic [BUS-1:0] wide;
      if (USED_O < BUS) begin : g_out_pad
         assign wide = {{(BUS-USED_O){1'b0}}, sums};
      end else begin : g_out_full
         assign wide = sums;
      end

      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               v_o <= 1'b0;
               d_o <= '0;
            end else begin
               v_o <= v_i;
               d_o <= wide;
            end
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign v_o = v_i;
         assign d_o = wide;
      end
   endgenerate

endmodule

// File: rtl/tern_adder_tree.sv
module tern_adder_tree import tern_pkg::*; #(
   parameter int  N         = 16,
   parameter bit  PIPELINED = 1'b1,
   localparam int WOUT      = trits_for(N)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [2*N-1:0]  in_trits,
   output logic            out_valid,
   output logic [2*WOUT-1:0] out_sum
);

   localparam int LEVELS = $clog2(N);
   localparam int BUS    = 2 * N;

   if (N < 2 || N > 128 || (N & (N - 1)) != 0) begin : g_bad_n
      $error("tern_adder_tree: N must be a power of two from 2 to 128");
   end

   logic           lvl_v [0:LEVELS];
   logic [BUS-1:0] lvl_d [0:LEVELS];

   assign lvl_v[0] = in_valid;
   assign lvl_d[0] = in_trits;

   generate
      for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
         localparam int WI    = (k == 0) ? 1 : trits_for(1 << k);
         localparam int WO    = trits_for(1 << (k + 1));
         localparam int PAIRS = N >> (k + 1);

         tern_stage #(
            .BUS   (BUS),
            .PAIRS (PAIRS),
            .W_IN  (WI),
            .W_OUT (WO),
            .REG   (PIPELINED)
         ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (lvl_v[k]),
            .d_i   (lvl_d[k]),
            .v_o   (lvl_v[k+1]),
            .d_o   (lvl_d[k+1])
         );
      end

      if (2 * WOUT < BUS) begin : g_top_pad
         logic unused_hi;
         assign unused_hi = ^lvl_d[LEVELS][BUS-1:2*WOUT];
      end
   endgenerate

   assign out_valid = lvl_v[LEVELS];
   assign out_sum   = lvl_d[LEVELS][2*WOUT-1:0];

endmodule

// File: rtl/tern_adder_tree_chk.sv
module tern_adder_tree_chk import tern_pkg::*; #(
   parameter int N         = 16,
   parameter bit PIPELINED = 1'b1,
   parameter int WOUT      = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [2*N-1:0]    in_trits,
   input logic              out_valid,
   input logic [2*WOUT-1:0] out_sum
);

   localparam int LAT = PIPELINED ? $clog2(N) : 0;

   int   in_val;
   int   out_val;
   logic bad_code;

   always_comb begin
      in_val = 0;
      for (int i = 0; i < N; i++) in_val += int'(t2i(in_trits[2*i +: 2]));
   end

   always_comb begin
      int w;
      out_val  = 0;
      bad_code = 1'b0;
      w        = 1;
      for (int j = 0; j < WOUT; j++) begin
         out_val += w * int'(t2i(out_sum[2*j +: 2]));
         if (out_sum[2*j +: 2] == 2'b10) bad_code = 1'b1;
         w = w * 3;
      end
   end

   // R3
   p_code_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !bad_code);

   // R4
   p_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (out_val <= N) && (out_val >= -N));

   generate
      if (LAT > 0) begin : g_pipe
         logic sh_v [LAT];
         int   sh_s [LAT];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < LAT; i++) begin
                  sh_v[i] <= 1'b0;
                  sh_s[i] <= 0;
               end
            end else begin
               sh_v[0] <= in_valid;
               sh_s[0] <= in_val;
               for (int i = 1; i < LAT; i++) begin
                  sh_v[i] <= sh_v[i-1];
                  sh_s[i] <= sh_s[i-1];
               end
            end
         end

         // R5
         p_valid_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == sh_v[LAT-1]);

         // R2 / R8
         p_sum_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> out_val == sh_s[LAT-1]);
      end else begin : g_comb
         // R6
         p_valid_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);

         // R2
         p_sum_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |-> out_val == in_val);
      end
   endgenerate

endmodule

bind tern_adder_tree tern_adder_tree_chk #(
   .N         (N),
   .PIPELINED (PIPELINED),
   .WOUT      (WOUT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_trits  (in_trits),
   .out_valid (out_valid),
   .out_sum   (out_sum)
);

// File: tb/sim_tern_adder_tree.sv
module sim_tern_adder_tree;

   localparam int CLK_PERIOD = 10;
   localparam int N   = 16;
   localparam int WO  = 4;   // ceil(log3(33))
   localparam int LAT = 4;   // log2(16)

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2*N-1:0] in_trits = '0;
   logic          v0, v1;
   logic [2*WO-1:0] s0, s1;

   int checks = 0;
   int errors = 0;
   int m = 0;
   bit done = 0;
   bit hv [16];
   int hs [16];

   always #(CLK_PERIOD/2) clk = ~clk;

   tern_adder_tree #(.N(N), .PIPELINED(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_trits(in_trits),
      .out_valid(v0), .out_sum(s0));

   tern_adder_tree #(.N(N), .PIPELINED(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_trits(in_trits),
      .out_valid(v1), .out_sum(s1));

   function automatic int code_val(logic [1:0] c);
      if (c == 2'b01) return 1;
      if (c == 2'b11) return -1;
      return 0;
   endfunction

   function automatic int vec_sum(logic [2*N-1:0] v);
      int acc = 0;
      for (int i = 0; i < N; i++) acc += code_val(v[2*i +: 2]);
      return acc;
   endfunction

   function automatic int word_val(logic [2*WO-1:0] w);
      int acc = 0;
      int p = 1;
      for (int j = 0; j < WO; j++) begin
         acc += p * code_val(w[2*j +: 2]);
         p = p * 3;
      end
      return acc;
   endfunction

   function automatic bit word_legal(logic [2*WO-1:0] w);
      for (int j = 0; j < WO; j++) if (w[2*j +: 2] == 2'b10) return 0;
      return 1;
   endfunction

   function automatic logic [2*N-1:0] fill(logic [1:0] c);
      logic [2*N-1:0] v;
      for (int i = 0; i < N; i++) v[2*i +: 2] = c;
      return v;
   endfunction

   function automatic logic [2*N-1:0] alt(logic [1:0] even, logic [1:0] odd);
      logic [2*N-1:0] v;
      for (int i = 0; i < N; i++) v[2*i +: 2] = (i % 2 == 0) ? even : odd;
      return v;
   endfunction

   function automatic logic [2*N-1:0] rnd_vec(bit with_bad);
      logic [2*N-1:0] v;
      for (int i = 0; i < N; i++) begin
         int r;
         r = with_bad ? int'($urandom % 4) : int'($urandom % 3);
         case (r)
            0: v[2*i +: 2] = 2'b01;
            1: v[2*i +: 2] = 2'b11;
            2: v[2*i +: 2] = 2'b00;
            default: v[2*i +: 2] = 2'b10;
         endcase
      end
      return v;
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock of traffic: check pipelined output for the vector LAT steps
   // back, then drive the new vector and check the combinational build
   task automatic step(logic [2*N-1:0] vec, bit v, string req);
      bit ev;
      int es;
      @(negedge clk);
      ev = (m >= LAT) ? hv[(m - LAT) % 16] : 1'b0;
      es = (m >= LAT) ? hs[(m - LAT) % 16] : 0;
      chk(v0 == ev, "R5", int'(v0), int'(ev));
      if (ev) chk(word_val(s0) == es, req, word_val(s0), es);
      chk(word_legal(s0), "R3", int'(s0), 0);
      in_trits = vec;
      in_valid = v;
      hv[m % 16] = v;
      hs[m % 16] = vec_sum(vec);
      m++;
      #1;
      chk(v1 == v, "R6", int'(v1), int'(v));
      chk(word_val(s1) == vec_sum(vec), "R6", word_val(s1), vec_sum(vec));
      chk(word_legal(s1), "R3", int'(s1), 0);
   endtask

   task automatic flush();
      for (int i = 0; i < LAT; i++) step('0, 1'b0, "R5");
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b1;
      in_trits = fill(2'b01);
      #1;
      chk(v0 == 1'b0, "R7", int'(v0), 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(v0 == 1'b0, "R7", int'(v0), 0);
         chk(s0 == '0, "R7", int'(s0), 0);
      end
      in_valid = 1'b0;
      in_trits = '0;
      rst_n = 1'b1;
      m = 0;
      for (int i = 0; i < 16; i++) begin
         hv[i] = 1'b0;
         hs[i] = 0;
      end
   endtask

   task automatic t_extremes();
      step(fill(2'b01), 1'b1, "R9");
      step(fill(2'b11), 1'b1, "R9");
      step(fill(2'b00), 1'b1, "R2");
      flush();
      // exact word layout of the extremes, R4
      step(fill(2'b01), 1'b1, "R4");
      #1;
      chk(s1 == 8'b01_11_11_01, "R4", int'(s1), 8'b01_11_11_01);
      step(fill(2'b11), 1'b1, "R4");
      #1;
      chk(s1 == 8'b11_01_01_11, "R4", int'(s1), 8'b11_01_01_11);
      flush();
   endtask

   task automatic t_alternating();
      step(alt(2'b01, 2'b11), 1'b1, "R9");
      step(alt(2'b01, 2'b00), 1'b1, "R9");
      step(alt(2'b11, 2'b00), 1'b1, "R9");
      step(alt(2'b00, 2'b01), 1'b1, "R9");
      step({fill(2'b11)} & {{N{2'b11}}} & {{(N/2){2'b11}}, {(N/2){2'b00}}}
           | {{(N/2){2'b00}}, {(N/2){2'b01}}}, 1'b1, "R9");
      flush();
   endtask

   task automatic t_bad_code();
      step(fill(2'b10), 1'b1, "R1");
      step(alt(2'b10, 2'b01), 1'b1, "R1");
      step(alt(2'b11, 2'b10), 1'b1, "R1");
      for (int i = 0; i < N; i++) begin
         logic [2*N-1:0] v;
         v = fill(2'b10);
         v[2*i +: 2] = (i % 2 == 0) ? 2'b01 : 2'b11;
         step(v, 1'b1, "R1");
      end
      for (int i = 0; i < 6; i++) step(rnd_vec(1'b1), 1'b1, "R1");
      flush();
   endtask

   task automatic t_stream();
      for (int i = 0; i < 60; i++) step(rnd_vec(1'b0), 1'b1, "R8");
      flush();
   endtask

   task automatic t_gaps();
      for (int i = 0; i < 60; i++) step(rnd_vec(1'b0), 1'($urandom % 2), "R5");
      flush();
   endtask

   task automatic t_reset_mid();
      for (int i = 0; i < 3; i++) step(fill(2'b01), 1'b1, "R7");
      @(negedge clk);
      #1;
      rst_n = 1'b0;
      #1;
      chk(v0 == 1'b0, "R7", int'(v0), 0);
      chk(s0 == '0, "R7", int'(s0), 0);
      do_reset();
      flush();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      void'($urandom(7));
      do_reset();
      flush();
      t_extremes();
      t_alternating();
      t_bad_code();
      t_stream();
      t_gaps();
      t_reset_mid();
      t_stream();
      finish_run();
   end

endmodule